// File: doc/BRIEF.md
# DMA Request/Acknowledge Routing Matrix

This block is a static, register-programmed crossbar between a large population of peripheral DMA request lines and a small set of DMA controller channels. On the request side, every DMA channel owns a select field holding a peripheral request number; the line with that number becomes the channel's request input. On the acknowledge side, every peripheral acknowledge output owns a select field holding a DMA channel index; that channel's acknowledge line is passed back to the peripheral. The two directions are therefore indexed in opposite ways: request routing is indexed by channel, acknowledge routing by acknowledge number.

Once the fields are written, the level-based request/acknowledge handshake passes through purely combinationally on every burst, with no register activity per transfer. Software programs both directions before a transfer and writes the unassigned value (all ones) back when the channel is released or a transfer times out.

Acknowledge numbers are not the same as request numbers. The block contains a piecewise-linear translator that turns a request number into its acknowledge number. It is exposed on a lookup port, and it also backs a "route by request number" write, so software can set up acknowledge routing from the request number alone.

Top module: `dma_route_matrix`

## Requirements
- R1: After reset every request-select field reads 0x1FF and every acknowledge-select field reads 0xF; all `ch_req` and `periph_ack` bits are low.
- R2: A write with `cfg_addr` = k (k < NUM_CH) stores `cfg_wdata[8:0]` in channel k's request field; it reads back at the same address from the next cycle, and `ch_req[k]` then equals `periph_req[field]` combinationally.
- R3: A request field holding a value of NUM_PREQ (437) or more drives its `ch_req` bit low.
- R4: A write with `cfg_addr` = 0x100 + a (a < NUM_ACK) stores `cfg_wdata[3:0]` in acknowledge field a; it reads back from the next cycle, and `periph_ack[a]` then equals `ch_ack[field]`.
- R5: An acknowledge field holding a value of NUM_CH (8) or more drives its `periph_ack` bit low.
- R6: Lookup maps request numbers 0 to 4 onto acknowledge numbers 84 to 88, in order, with `lk_valid` high.
- R7: Lookup maps request numbers 0x161 to 0x198 onto acknowledge numbers 28 to 83, in order, with `lk_valid` high.
- R8: Lookup maps request numbers 0x199 to 0x1B4 onto acknowledge numbers 0 to 27, in order, with `lk_valid` high.
- R9: Any other request number gives `lk_valid` low and `lk_ack_no` zero.
- R10: A write to `cfg_addr` 0x200 carries a request number in `cfg_wdata[8:0]` and a channel in `cfg_wdata[12:9]`; it stores the channel in the acknowledge field of the translated number, and changes no field when the request number is outside the mapped ranges.
- R11: Several channels may select the same request number and all see it; each acknowledge output follows only the channel named in its own field.
- R12: Reads at addresses that hold no field return zero, and writes there change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 10 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Field value at `cfg_addr` (combinational) |
| lk_req_no | input | 9 | Request number to translate |
| lk_valid | output | 1 | Request number lies in a mapped range |
| lk_ack_no | output | 7 | Translated acknowledge number |
| periph_req | input | 437 | Peripheral request lines, indexed by request number |
| ch_req | output | 8 | Request to each DMA channel |
| ch_ack | input | 8 | Acknowledge from each DMA channel |
| periph_ack | output | 89 | Acknowledge to each peripheral, indexed by acknowledge number |

## Verification
Field writes land at the clock edge that samples `cfg_we`, so read-back and routing effects are due in the cycle after the write; the bench drives writes on the falling edge and looks at results one falling edge later. The lookup port, the read port and both routing paths are combinational from their inputs, so after every change to `periph_req`, `ch_ack`, `cfg_addr` or `lk_req_no` the bench waits one nanosecond, without any clock edge, before sampling. Expected routing comes from a shadow copy of the fields kept by the bench and a translation function written as separate range tests.

// File: rtl/dma_rt_pkg.sv
package dma_rt_pkg;

  localparam int REQ_W = 9;
  localparam int ACK_W = 7;

  // Translation ranges
  localparam int PIN_LO  = 0;
  localparam int PIN_HI  = 4;
  localparam int PIN_ACK = 84;
  localparam int AUD_LO  = 353;  // 0x161
  localparam int AUD_HI  = 408;  // 0x198
  localparam int AUD_ACK = 28;
  localparam int MIX_LO  = 409;  // 0x199
  localparam int MIX_HI  = 436;  // 0x1B4
  localparam int MIX_ACK = 0;

  typedef struct packed {
    logic             valid;
    logic [ACK_W-1:0] num;
  } ack_map_t;

  function automatic ack_map_t map_req_to_ack(input logic [REQ_W-1:0] r);
    ack_map_t m;
    int       v;
    v = int'(r);
    m = '0;
    if (v >= PIN_LO && v <= PIN_HI) begin
      m.valid = 1'b1;
      m.num   = ACK_W'(v - PIN_LO + PIN_ACK);
    end else if (v >= AUD_LO && v <= AUD_HI) begin
      m.valid = 1'b1;
      m.num   = ACK_W'(v - AUD_LO + AUD_ACK);
    end else if (v >= MIX_LO && v <= MIX_HI) begin
      m.valid = 1'b1;
      m.num   = ACK_W'(v - MIX_LO + MIX_ACK);
    end
    return m;
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_rt_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_ACK = 89,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int CHS_W   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic [NUM_CH-1:0][REQ_W-1:0]       req_sel,
  output logic [NUM_ACK-1:0][CHS_W-1:0]      ack_sel,
  output logic                               wr_req_hit,
  output logic                               wr_ack_hit,
  output logic                               wr_byreq_try,
  output logic                               wr_byreq_hit
);

  localparam int IDX_W      = ADDR_W - 2;
  localparam int CH_IDX_W   = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1;
  localparam int ACK_IDX_W  = (NUM_ACK > 1) ? $clog2(NUM_ACK) : 1;
  localparam logic [IDX_W-1:0] CH_LIM  = IDX_W'(NUM_CH);
  localparam logic [IDX_W-1:0] ACK_LIM = IDX_W'(NUM_ACK);

  localparam logic [1:0] RG_REQ   = 2'd0;
  localparam logic [1:0] RG_ACK   = 2'd1;
  localparam logic [1:0] RG_BYREQ = 2'd2;

  logic [1:0]           region;
  logic [IDX_W-1:0]     idx;
  logic                 ch_ok, ack_ok;
  logic [CH_IDX_W-1:0]  ch_i;
  logic [ACK_IDX_W-1:0] ack_i;
  ack_map_t             bmap;
  logic [ACK_IDX_W-1:0] bmap_i;
  logic [CHS_W-1:0]     bchan;

  assign region = addr[ADDR_W-1 -: 2];
  assign idx    = addr[IDX_W-1:0];
  assign ch_ok  = (idx < CH_LIM);
  assign ack_ok = (idx < ACK_LIM);
  assign ch_i   = idx[CH_IDX_W-1:0];
  assign ack_i  = idx[ACK_IDX_W-1:0];

  assign bmap   = map_req_to_ack(wdata[REQ_W-1:0]);
  assign bmap_i = ACK_IDX_W'(bmap.num);
  assign bchan  = wdata[REQ_W +: CHS_W];

  assign wr_req_hit   = we && (region == RG_REQ) && ch_ok;
  assign wr_ack_hit   = we && (region == RG_ACK) && ack_ok;
  assign wr_byreq_try = we && (region == RG_BYREQ) && (idx == '0);
  assign wr_byreq_hit = wr_byreq_try && bmap.valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sel <= '1;
      ack_sel <= '1;
    end else begin
      if (wr_req_hit)   req_sel[ch_i]   <= wdata[REQ_W-1:0];
      if (wr_ack_hit)   ack_sel[ack_i]  <= wdata[CHS_W-1:0];
      if (wr_byreq_hit) ack_sel[bmap_i] <= bchan;
    end
  end

  always_comb begin
    rdata = '0;
    if (region == RG_REQ && ch_ok)
      rdata = DATA_W'(req_sel[ch_i]);
    else if (region == RG_ACK && ack_ok)
      rdata = DATA_W'(ack_sel[ack_i]);
  end

endmodule

// File: rtl/dma_req_mux.sv
module dma_req_mux
  import dma_rt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PREQ = 437
) (
  input  logic [NUM_CH-1:0][REQ_W-1:0] req_sel,
  input  logic [NUM_PREQ-1:0]          periph_req,
  output logic [NUM_CH-1:0]            ch_req
);

  localparam logic [REQ_W-1:0] PREQ_LIM = REQ_W'(NUM_PREQ);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_req[k] = (req_sel[k] < PREQ_LIM) ? periph_req[req_sel[k]] : 1'b0;
  end

endmodule

// File: rtl/dma_ack_mux.sv
module dma_ack_mux #(
  parameter int NUM_CH  = 8,
  parameter int NUM_ACK = 89,
  parameter int CHS_W   = 4
) (
  input  logic [NUM_ACK-1:0][CHS_W-1:0] ack_sel,
  input  logic [NUM_CH-1:0]             ch_ack,
  output logic [NUM_ACK-1:0]            periph_ack
);

  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CHS_W-1:0] CH_LIM = CHS_W'(NUM_CH);

  for (genvar a = 0; a < NUM_ACK; a++) begin : g_ack
    logic [CH_IDX_W-1:0] src;
    assign src           = ack_sel[a][CH_IDX_W-1:0];
    assign periph_ack[a] = (ack_sel[a] < CH_LIM) ? ch_ack[src] : 1'b0;
  end

endmodule

// File: rtl/dma_route_matrix.sv
module dma_route_matrix
  import dma_rt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PREQ = 437,
  parameter int NUM_ACK  = 89,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [REQ_W-1:0]    lk_req_no,
  output logic                lk_valid,
  output logic [ACK_W-1:0]    lk_ack_no,
  input  logic [NUM_PREQ-1:0] periph_req,
  output logic [NUM_CH-1:0]   ch_req,
  input  logic [NUM_CH-1:0]   ch_ack,
  output logic [NUM_ACK-1:0]  periph_ack
);

  localparam int CHS_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0][REQ_W-1:0]  req_sel;
  logic [NUM_ACK-1:0][CHS_W-1:0] ack_sel;
  logic wr_req_hit, wr_ack_hit, wr_byreq_try, wr_byreq_hit;
  ack_map_t lk_map;

  assign lk_map    = map_req_to_ack(lk_req_no);
  assign lk_valid  = lk_map.valid;
  assign lk_ack_no = lk_map.num;

  dma_cfg_regs #(
    .NUM_CH(NUM_CH), .NUM_ACK(NUM_ACK), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CHS_W(CHS_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .req_sel(req_sel), .ack_sel(ack_sel),
    .wr_req_hit(wr_req_hit), .wr_ack_hit(wr_ack_hit),
    .wr_byreq_try(wr_byreq_try), .wr_byreq_hit(wr_byreq_hit)
  );

  dma_req_mux #(.NUM_CH(NUM_CH), .NUM_PREQ(NUM_PREQ)) u_req (
    .req_sel(req_sel), .periph_req(periph_req), .ch_req(ch_req)
  );

  dma_ack_mux #(.NUM_CH(NUM_CH), .NUM_ACK(NUM_ACK), .CHS_W(CHS_W)) u_ack (
    .ack_sel(ack_sel), .ch_ack(ch_ack), .periph_ack(periph_ack)
  );

endmodule

// File: rtl/dma_route_matrix_chk.sv
module dma_route_matrix_chk
  import dma_rt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PREQ = 437,
  parameter int NUM_ACK  = 89,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int CHS_W    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [ADDR_W-1:0]             cfg_addr,
  input logic [DATA_W-1:0]             cfg_wdata,
  input logic [REQ_W-1:0]              lk_req_no,
  input logic                          lk_valid,
  input logic [ACK_W-1:0]              lk_ack_no,
  input logic [NUM_PREQ-1:0]           periph_req,
  input logic [NUM_CH-1:0]             ch_req,
  input logic [NUM_CH-1:0]             ch_ack,
  input logic [NUM_ACK-1:0]            periph_ack,
  input logic [NUM_CH-1:0][REQ_W-1:0]  req_sel,
  input logic [NUM_ACK-1:0][CHS_W-1:0] ack_sel,
  input logic                          wr_byreq_try,
  input logic                          wr_byreq_hit
);

  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [REQ_W-1:0] PREQ_LIM = REQ_W'(NUM_PREQ);
  localparam logic [CHS_W-1:0] CH_LIM   = CHS_W'(NUM_CH);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    // R2: field written at its address holds the data one cycle later
    a_r2_req_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(k)) |=> req_sel[k] == $past(cfg_wdata[REQ_W-1:0]));
    // R2: assigned channel follows the selected peripheral line
    a_r2_req_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sel[k] < PREQ_LIM) |-> ch_req[k] == periph_req[req_sel[k]]);
    // R3: unassigned channel request stays low
    a_r3_req_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sel[k] >= PREQ_LIM) |-> !ch_req[k]);
  end

  for (genvar a = 0; a < NUM_ACK; a++) begin : g_ack
    // R4 / R11: acknowledge follows only the named channel
    a_r4_ack_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_sel[a] < CH_LIM) |-> periph_ack[a] == ch_ack[ack_sel[a][CH_IDX_W-1:0]]);
    // R5: unassigned acknowledge stays low
    a_r5_ack_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_sel[a] >= CH_LIM) |-> !periph_ack[a]);
  end

  // R6, R7, R8: translated number lands in its group's window
  a_r6_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_no <= 9'd4) |-> (lk_valid && lk_ack_no >= 7'd84 && lk_ack_no <= 7'd88));
  a_r7_aud_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_no >= 9'h161 && lk_req_no <= 9'h198) |-> (lk_valid && lk_ack_no >= 7'd28 && lk_ack_no <= 7'd83));
  a_r8_mix_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_no >= 9'h199 && lk_req_no <= 9'h1B4) |-> (lk_valid && lk_ack_no <= 7'd27));
  // R9: unmapped number gives no acknowledge number
  a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> lk_ack_no == '0);
  // R10: suppressed write leaves every acknowledge field unchanged
  a_r10_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byreq_try && !wr_byreq_hit) |=> $stable(ack_sel));

endmodule

bind dma_route_matrix dma_route_matrix_chk #(
  .NUM_CH(NUM_CH), .NUM_PREQ(NUM_PREQ), .NUM_ACK(NUM_ACK),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHS_W(CHS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .lk_req_no(lk_req_no), .lk_valid(lk_valid),
  .lk_ack_no(lk_ack_no), .periph_req(periph_req), .ch_req(ch_req),
  .ch_ack(ch_ack), .periph_ack(periph_ack), .req_sel(req_sel),
  .ack_sel(ack_sel), .wr_byreq_try(wr_byreq_try), .wr_byreq_hit(wr_byreq_hit)
);

// File: tb/dma_route_matrix_test.sv
`timescale 1ns/1ps
module dma_route_matrix_test;

  localparam int NCH = 8;
  localparam int NPR = 437;
  localparam int NAK = 89;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [9:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic [15:0]  cfg_rdata;
  logic [8:0]   lk_req_no = '0;
  logic         lk_valid;
  logic [6:0]   lk_ack_no;
  logic [NPR-1:0] periph_req = '0;
  logic [NCH-1:0] ch_req;
  logic [NCH-1:0] ch_ack = '0;
  logic [NAK-1:0] periph_ack;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_req [NCH];
  int m_ack [NAK];

  always #2 clk = ~clk;

  dma_route_matrix uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req_no(lk_req_no),
    .lk_valid(lk_valid), .lk_ack_no(lk_ack_no), .periph_req(periph_req),
    .ch_req(ch_req), .ch_ack(ch_ack), .periph_ack(periph_ack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent restatement of the number translation
  function automatic int exp_ack(input int r, output bit v);
    v = 1'b1;
    if (r < 5) return 84 + r;
    if (r >= 'h161 && r < 'h199) return r - 'h161 + 28;
    if (r >= 'h199 && r < 'h1B5) return r - 'h199;
    v = 1'b0;
    return 0;
  endfunction

  task automatic wr(input int addr, input int data);
    int reg_n, ix;
    bit v;
    int a;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    reg_n = addr >> 8; ix = addr & 'hFF;
    if (reg_n == 0 && ix < NCH) m_req[ix] = data & 'h1FF;
    else if (reg_n == 1 && ix < NAK) m_ack[ix] = data & 'hF;
    else if (reg_n == 2 && ix == 0) begin
      a = exp_ack(data & 'h1FF, v);
      if (v) m_ack[a] = (data >> 9) & 'hF;
    end
  endtask

  task automatic rd(input int addr, input int exp, input string req);
    cfg_addr = 10'(addr);
    #1;
    chk(int'(cfg_rdata) == exp, req, cfg_rdata, exp);
  endtask

  task automatic route_check(input string req);
    logic [NCH-1:0] e_ch;
    logic [NAK-1:0] e_pa;
    #1;
    for (int k = 0; k < NCH; k++) e_ch[k] = (m_req[k] < NPR) ? periph_req[m_req[k]] : 1'b0;
    for (int a = 0; a < NAK; a++) e_pa[a] = (m_ack[a] < NCH) ? ch_ack[m_ack[a]] : 1'b0;
    chk(ch_req == e_ch, {req, " ch_req"}, ch_req, e_ch);
    chk(periph_ack == e_pa, {req, " periph_ack"}, 0, 0);
    if (periph_ack != e_pa) $display("  periph_ack act=%h exp=%h", periph_ack, e_pa);
  endtask

  task automatic lk(input int r, input string req);
    bit v;
    int e;
    e = exp_ack(r, v);
    lk_req_no = 9'(r);
    #1;
    chk(lk_valid == v, {req, " valid"}, lk_valid, v);
    chk(int'(lk_ack_no) == e, {req, " ack_no"}, lk_ack_no, e);
  endtask

  task automatic rand_inputs();
    for (int i = 0; i < NPR; i++) periph_req[i] = $urandom_range(0, 1);
    ch_ack = NCH'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NCH; k++) m_req[k] = 'h1FF;
    for (int a = 0; a < NAK; a++) m_ack[a] = 'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    periph_req = '1; ch_ack = '1;
    #1;
    chk(ch_req == '0, "R1 ch_req low", ch_req, 0);
    chk(periph_ack == '0, "R1 periph_ack low", 0, 0);
    rd(3, 'h1FF, "R1 req field");
    rd('h100 + 88, 'hF, "R1 ack field");

    // R6..R9: translation corners
    lk(0, "R6"); lk(4, "R6"); lk(2, "R6");
    lk('h161, "R7"); lk('h198, "R7"); lk('h17A, "R7");
    lk('h199, "R8"); lk('h1B4, "R8"); lk('h1A0, "R8");
    lk(5, "R9"); lk('h160, "R9"); lk('h1B5, "R9"); lk('h1FF, "R9");
    for (int i = 0; i < 100; i++) lk($urandom_range(0, 511), "R6-9 random R9");

    // R2: direct request routing
    for (int k = 0; k < NCH; k++) wr(k, $urandom_range(0, NPR - 1));
    for (int k = 0; k < NCH; k++) rd(k, m_req[k], "R2 readback");
    for (int i = 0; i < 5; i++) begin rand_inputs(); route_check("R2"); end
    // R3: out-of-range request number
    wr(2, 437); wr(5, 500);
    periph_req = '1; route_check("R3");
    // R11: two channels share a request line
    wr(0, 'h170); wr(1, 'h170);
    periph_req = '0; periph_req['h170] = 1'b1;
    #1;
    chk(ch_req[0] && ch_req[1], "R11 shared request", ch_req, 3);

    // R4: direct acknowledge routing
    for (int a = 0; a < NAK; a += 7) wr('h100 + a, $urandom_range(0, NCH - 1));
    rd('h100 + 14, m_ack[14], "R4 readback");
    for (int i = 0; i < 5; i++) begin rand_inputs(); route_check("R4"); end
    // R11: only named channel drives the acknowledge
    wr('h100 + 50, 1);
    ch_ack = 8'b0000_0001;
    #1;
    chk(periph_ack[50] == 1'b0, "R11 other channel ignored", periph_ack[50], 0);
    ch_ack = 8'b0000_0010;
    #1;
    chk(periph_ack[50] == 1'b1, "R11 named channel", periph_ack[50], 1);
    // R5: out-of-range channel values
    wr('h100 + 50, 8); wr('h100 + 51, 15);
    ch_ack = '1; route_check("R5");

    // R10: route by request number
    wr('h200, (3 << 9) | 'h000);       // ack 84 <- ch3
    rd('h100 + 84, 3, "R10 pin group");
    wr('h200, (6 << 9) | 'h198);       // ack 83 <- ch6
    rd('h100 + 83, 6, "R10 audio group");
    wr('h200, (2 << 9) | 'h199);       // ack 0 <- ch2
    rd('h100 + 0, 2, "R10 mixer group");
    wr('h200, (5 << 9) | 'h160);       // invalid, suppressed
    for (int a = 0; a < NAK; a++) begin
      cfg_addr = 10'('h100 + a);
      #1;
      if (int'(cfg_rdata) != m_ack[a]) chk(1'b0, "R10 suppressed", cfg_rdata, m_ack[a]);
    end
    chk(1'b1, "R10 suppressed sweep", 0, 0);
    rand_inputs(); route_check("R10");

    // R12: addresses without a field
    wr('h0F0, 'h12); wr('h1FF, 'h3); wr('h300, 'h55); wr('h201, (1 << 9) | 'h1);
    rd('h0F0, 0, "R12 read gap");
    rd('h1FF, 0, "R12 read gap");
    rd('h300, 0, "R12 read gap");
    rand_inputs(); route_check("R12 writes ignored");

    // R1-style release: clear everything back to unassigned
    for (int k = 0; k < NCH; k++) wr(k, 'h1FF);
    for (int a = 0; a < NAK; a++) wr('h100 + a, 'hF);
    periph_req = '1; ch_ack = '1;
    #1;
    chk(ch_req == '0 && periph_ack == '0, "R3 R5 released", ch_req, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel, ad, dt;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin ad = $urandom_range(0, 9); dt = $urandom_range(0, 511); end
      else if (sel < 6) begin ad = 'h100 + $urandom_range(0, 95); dt = $urandom_range(0, 15); end
      else if (sel < 9) begin ad = 'h200; dt = ($urandom_range(0, 15) << 9) | $urandom_range(0, 511); end
      else begin ad = $urandom_range(0, 1023); dt = $urandom_range(0, 65535); end
      wr(ad, dt);
      rand_inputs();
      route_check("R2 R4 R10 random");
      if (i % 8 == 0) rd(ad, ((ad >> 8) == 0 && (ad & 'hFF) < NCH) ? m_req[ad & 'hFF] :
                             ((ad >> 8) == 1 && (ad & 'hFF) < NAK) ? m_ack[ad & 'hFF] : 0,
                        "R12 R2 R4 random read");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule